// File: doc/BRIEF.md
# Serial PRBS Checker with Self-Loading Lock

This block is the receive half of a bit-error-rate tester. It takes a serial stream, one bit per enabled clock, that a transmitter made with an 11-stage maximal-length shift register. It rebuilds the same sequence locally and reports every received bit that differs from the predicted one. To find the phase of the sequence, it does not search. It copies received bits straight into its own shift register until the register is full. It then checks that the register agrees with the line for a fixed run of bits. Only after that does it cut the register loose to run on its own feedback.

Once locked, the checker runs its register from its own taps, so a line error gives exactly one error strobe. A running total of errors sits in a saturating counter. A pulse once per second marks the integration interval. If the errors counted inside one interval go past a threshold set at a port, the checker drops lock and starts acquisition again. Constant and other degenerate inputs are kept from producing a false lock.

Top module: `prbs_checker`

## Requirements
- R1: After reset, `sync_n` is 1, `err_o` is 0 and `err_cnt` is 0.
- R2: The local sequence uses x^11 + x^9 + 1. Each new bit enters stage 1, and the predicted bit is the XOR of stages 11 and 9. With a clean stream from reset, `sync_n` falls on exactly the 43rd enabled bit: 11 load bits followed by 32 agreeing bits.
- R3: A mismatch between a received bit and the predicted bit during the 32-bit agreement window restarts loading from the next bit. Errors seen before lock never change `err_cnt`.
- R4: Constant all-zeros, constant all-ones and alternating 0/1 input never lock. A register that holds all zeros or all ones when loading finishes forces a new load.
- R5: While locked, each received bit that differs from the predicted bit raises `err_o` for exactly one clock, in the cycle after that bit is sampled. The same bit raises `err_cnt` by one.
- R6: While locked, the local register advances on its own feedback, so one line error yields one strobe and no further errors.
- R7: When a locked bit is in error and the count already integrated in the current interval is at least `err_thr`, `sync_n` goes to 1 after that bit and acquisition restarts.
- R8: An enabled bit with `sec_pulse` high clears the interval count, and an error on that same bit is not integrated. If no interval holds more than `err_thr` errors, lock is kept.
- R9: `err_cnt` saturates at all ones and does not wrap.
- R10: With `ce` low, no state changes and `err_o` stays 0, whatever `din` does.
- R11: After lock is lost, a clean stream is locked onto again with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Bit enable; one received bit per enabled clock |
| din | input | 1 | Received serial bit |
| sec_pulse | input | 1 | Interval marker, high for one enabled bit |
| err_thr | input | THR_W | Errors allowed per interval before lock is dropped |
| sync_n | output | 1 | 0 when locked, 1 when out of lock |
| err_o | output | 1 | One-clock strobe per errored bit while locked |
| err_cnt | output | CNT_W | Saturating total of errors counted while locked |

## Verification
The bench measures lock time to the exact bit. A checker that is off by one in the load or window count locks one bit early or late. It places one error inside the agreement window. A design that ignored that error would lock 20 bits early, and one that counted it would show a non-zero total. Constant and alternating streams are sent. A design without the degenerate-state guard would lock on zeros. Single errors and bursts are placed around the threshold and the interval pulse. A register fed from the line while locked would show multiplied errors. An off-by-one threshold compare would drop lock one error too early or too late. A stuck interval clear would drop lock across two quiet intervals. A long run of errors is used to catch a counter that wraps, and a stretch with `ce` low carries line noise that a design must ignore.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } acq_state_e;
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int W    = 11,
  parameter int TAPA = 11,
  parameter int TAPB = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic load_sel,
  input  logic locked,
  input  logic din,
  output logic pred,
  output logic bad
);
  logic [W-1:0] sr_q, sr_d;
  logic         feed;

  assign pred = sr_q[TAPA-1] ^ sr_q[TAPB-1];
  assign bad  = (sr_q == '0) || (sr_q == '1);
  assign feed = load_sel ? din : pred;

  always_comb begin
    sr_d = sr_q;
    if (ce) sr_d = {sr_q[W-2:0], feed};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(sr_q)); // R10
  AST_LOCK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (sr_q != '0)); // R4
endmodule

// File: rtl/prbs_acq_fsm.sv
module prbs_acq_fsm
  import prbs_pkg::*;
#(
  parameter int W   = 11,
  parameter int WIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic din,
  input  logic pred,
  input  logic bad,
  input  logic drop,
  output logic load_sel,
  output logic locked
);
  localparam int MAXC = (W > WIN) ? W : WIN;
  localparam int CW   = $clog2(MAXC + 1);

  acq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_LOAD: if (ce) begin
        if (cnt_q == CW'(W - 1)) begin
          st_d  = ST_VERIFY;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_VERIFY: if (ce) begin
        if (((cnt_q == '0) && bad) || (pred != din)) begin
          st_d  = ST_LOAD;
          cnt_d = '0;
        end else if (cnt_q == CW'(WIN - 1)) begin
          st_d  = ST_LOCK;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOCK: if (drop) begin
        st_d  = ST_LOAD;
        cnt_d = '0;
      end
      default: begin
        st_d  = ST_LOAD;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign locked   = (st_q == ST_LOCK);
  assign load_sel = !locked;

  AST_LOCK_VIA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(st_q) == ST_VERIFY)); // R2
  AST_DROP_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !locked); // R7
endmodule

// File: rtl/prbs_err_integ.sv
module prbs_err_integ #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             locked,
  input  logic             mismatch,
  input  logic             sec_pulse,
  input  logic [THR_W-1:0] thr,
  output logic             drop,
  output logic             err_q,
  output logic [CNT_W-1:0] total_q
);
  logic             hit, tick;
  logic [THR_W-1:0] integ_q, integ_d;
  logic [CNT_W-1:0] total_d;

  assign hit  = ce && locked && mismatch;
  assign tick = ce && sec_pulse;
  assign drop = hit && !tick && (integ_q >= thr);

  always_comb begin
    integ_d = integ_q;
    if (!locked || tick || drop) integ_d = '0;
    else if (hit)                integ_d = integ_q + 1'b1;
    total_d = total_q;
    if (hit && (total_q != '1)) total_d = total_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      total_q <= '0;
      err_q   <= 1'b0;
    end else begin
      integ_q <= integ_d;
      total_q <= total_d;
      err_q   <= hit;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (total_q == $past(total_q) + 1'b1) ||
            (($past(total_q) == '1) && (total_q == '1))); // R9
  AST_COUNT_ONLY_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(total_q)); // R5
endmodule

// File: rtl/prbs_checker.sv
module prbs_checker #(
  parameter int W     = 11,
  parameter int TAPA  = 11,
  parameter int TAPB  = 9,
  parameter int WIN   = 32,
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             din,
  input  logic             sec_pulse,
  input  logic [THR_W-1:0] err_thr,
  output logic             sync_n,
  output logic             err_o,
  output logic [CNT_W-1:0] err_cnt
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       pred, bad, load_sel, locked, drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  prbs_lfsr #(.W(W), .TAPA(TAPA), .TAPB(TAPB)) u_lfsr (
    .clk(clk), .rst_n(rst_s), .ce(ce), .load_sel(load_sel), .locked(locked),
    .din(din), .pred(pred), .bad(bad)
  );

  prbs_acq_fsm #(.W(W), .WIN(WIN)) u_fsm (
    .clk(clk), .rst_n(rst_s), .ce(ce), .din(din), .pred(pred), .bad(bad),
    .drop(drop), .load_sel(load_sel), .locked(locked)
  );

  prbs_err_integ #(.CNT_W(CNT_W), .THR_W(THR_W)) u_integ (
    .clk(clk), .rst_n(rst_s), .ce(ce), .locked(locked),
    .mismatch(din ^ pred), .sec_pulse(sec_pulse), .thr(err_thr),
    .drop(drop), .err_q(err_o), .total_q(err_cnt)
  );

  assign sync_n = !locked;

  AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_s)
    err_o |-> $past(!sync_n)); // R5
endmodule

// File: tb/prbs_checker_bench.sv
module prbs_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic          din = 1'b0;
  logic          sec_pulse = 1'b0;
  logic [TW-1:0] err_thr = 8'd4;
  logic          sync_n, err_o;
  logic [CW-1:0] err_cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] gen;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_checker #(.CNT_W(CW), .THR_W(TW)) u_prbs_checker (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .sec_pulse(sec_pulse),
    .err_thr(err_thr), .sync_n(sync_n), .err_o(err_o), .err_cnt(err_cnt)
  );

  // pattern[10:9] (0 clean, 1 zeros, 2 ones, 3 alternating), bits[8:1], expected sync_n[0]
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 8'd42,  1'b1},
    {2'd0, 8'd43,  1'b0},
    {2'd1, 8'd200, 1'b1},
    {2'd2, 8'd200, 1'b1},
    {2'd3, 8'd200, 1'b1},
    {2'd0, 8'd100, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic c, input logic s);
    @(negedge clk);
    din = b; ce = c; sec_pulse = s;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic send(input logic flip, input logic s);
    logic nb;
    nb  = gen[10] ^ gen[8];
    gen = {gen[9:0], nb};
    drive(nb ^ flip, 1'b1, s);
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce = 1'b0; din = 1'b0; sec_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    gen = 11'h001;
  endtask

  initial begin
    int errs;
    logic v;
    do_reset();
    chk("R1 sync_n", sync_n, 1);
    chk("R1 err_o", err_o, 0);
    chk("R1 err_cnt", err_cnt, 0);

    for (int k = 0; k < 6; k++) begin
      do_reset();
      for (int i = 0; i < int'(VEC[k][8:1]); i++) begin
        unique case (VEC[k][10:9])
          2'd0: send(1'b0, 1'b0);
          2'd1: drive(1'b0, 1'b1, 1'b0);
          2'd2: drive(1'b1, 1'b1, 1'b0);
          default: drive(i[0], 1'b1, 1'b0);
        endcase
      end
      chk(VEC[k][10:9] == 2'd0 ? "R2 lock timing" : "R4 no false lock",
          sync_n, int'(VEC[k][0]));
      chk("R3 no count before lock", err_cnt, 0);
    end

    // single error, no multiplication
    do_reset();
    err_thr = 8'd4;
    clean(53);
    send(1'b1, 1'b0);
    chk("R5 strobe", err_o, 1);
    chk("R5 count", err_cnt, 1);
    send(1'b0, 1'b0);
    chk("R5 strobe one clock", err_o, 0);
    errs = 0;
    for (int i = 0; i < 50; i++) begin
      send(1'b0, 1'b0);
      if (err_o) errs++;
    end
    chk("R6 no error multiplication", errs, 0);
    chk("R6 count", err_cnt, 1);

    // burst within threshold, interval clear, exceed
    for (int i = 0; i < 3; i++) send(1'b1, 1'b0);
    chk("R8 burst keeps lock", sync_n, 0);
    chk("R5 burst count", err_cnt, 4);
    send(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) send(1'b1, 1'b0);
    chk("R8 cleared interval keeps lock", sync_n, 0);
    send(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) send(1'b1, 1'b0);
    chk("R7 at threshold still locked", sync_n, 0);
    send(1'b1, 1'b0);
    chk("R7 past threshold drops", sync_n, 1);
    chk("R7 count", err_cnt, 13);

    // reacquire
    begin
      int waited = 0;
      while (sync_n && waited < 120) begin
        send(1'b0, 1'b0);
        waited++;
      end
    end
    chk("R11 relock", sync_n, 0);
    chk("R11 count unchanged", err_cnt, 13);

    // clock enable low
    errs = 0;
    for (int i = 0; i < 20; i++) begin
      drive(i[0], 1'b0, 1'b0);
      if (err_o) errs++;
    end
    chk("R10 no strobe with ce low", errs, 0);
    clean(20);
    chk("R10 still locked", sync_n, 0);
    chk("R10 count held", err_cnt, 13);

    // mismatch inside verify window
    do_reset();
    clean(19);
    send(1'b1, 1'b0);
    clean(42);
    chk("R3 window restart late", sync_n, 1);
    send(1'b0, 1'b0);
    chk("R3 window restart lock", sync_n, 0);
    chk("R3 no count", err_cnt, 0);

    // saturation
    do_reset();
    err_thr = 8'd255;
    clean(43);
    for (int i = 0; i < 300; i++) begin
      v = (i % 100) == 0;
      send(1'b1, v);
    end
    chk("R9 saturate", err_cnt, 255);
    chk("R9 lock kept", sync_n, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule